// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single countdown timer controlled through a bank of 32-bit word registers. Software writes a start value, picks a counting mode, a counter width and a clock prescale in a control byte, and then sets the run bit. While running, the counter steps down by one on every prescaled tick. When the counter has reached zero, the next tick is an expiry. An expiry latches a raw interrupt flag, which stays set until software writes the clear register.

Three counting behaviours are available. Free-running mode ignores the stored start value and wraps to the all-ones count of the selected width. Periodic mode refills the counter from the stored start value. One-shot mode fires once and then parks at zero. There are two ways to set the start value. The immediate path also refills the counter at once. The deferred path changes only the value used at the next refill. The interrupt line is the raw flag qualified by an enable bit in the control byte.

Top module: `countdown_timer`

## Requirements
- R1: After reset, the control byte reads 0x20 (interrupt enable set, not running, free-running, 16-bit, prescale by 1), the count reads 0, the raw flag reads 0 and `irq_o` is low.
- R2: Registers are decoded on word index `addr_i[4:2]` with all other address bits zero: 0 start value (immediate), 1 count (read-only), 2 control, 3 flag clear (write-only, reads 0), 4 raw flag in bit 0, 5 masked flag in bit 0, 6 start value (deferred, reads the same as index 0). Any other address reads 0, and writes to it change nothing.
- R3: A write to index 0 stores the start value and places it in the counter on the same edge. A write to index 1 is ignored.
- R4: A write to index 6 stores the start value only. The counter keeps counting and takes up the new value at its next periodic refill.
- R5: The counter decrements by one per tick while control bit 7 is set, and holds its value while bit 7 is clear.
- R6: Control bits [3:2] select the tick rate. With 00 or 11 the counter ticks every cycle. With 01 it ticks every 16th cycle and with 10 every 256th cycle. A control write restarts the divider phase, so the first decrement lands on the 16th or 256th edge after that write.
- R7: With control bits 6 and 0 both clear, a tick at zero expires and wraps the count to 0xFFFF when bit 1 is clear, or to 0xFFFFFFFF when bit 1 is set.
- R8: With bit 6 set and bit 0 clear, a tick at zero expires and refills the counter with the stored start value on that same edge.
- R9: With bit 0 set, the first tick at zero expires. The counter then stays at 0 and does not expire again until index 0 or index 2 is written.
- R10: An expiry sets the raw flag on its own edge. Any write to index 3 clears the flag, but an expiry on the same edge wins.
- R11: The masked flag and `irq_o` both equal the raw flag ANDed with control bit 5.
- R12: With control bit 1 clear, only the low 16 bits of the counter take part in counting, and the count reads with bits [31:16] zero.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | Write when high, with `req_i` |
| addr_i | input | ADDR_W (12) | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 12-bit address, a 32-bit counter with a 16-bit narrow mode, and divider exponents of 4 and 8. These values put both wrap points (0xFFFF and 0xFFFFFFFF) within reach of a one-count start value. They also keep the divide-by-256 window short enough to observe the exact edge on which the first slow decrement lands. With the 12-bit address, the bench can place an access outside the decoded window and confirm that it has no effect.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int unsigned REG_W = 32;

  localparam logic [2:0] IDX_LOAD   = 3'd0;
  localparam logic [2:0] IDX_VALUE  = 3'd1;
  localparam logic [2:0] IDX_CTRL   = 3'd2;
  localparam logic [2:0] IDX_ICLR   = 3'd3;
  localparam logic [2:0] IDX_RAW    = 3'd4;
  localparam logic [2:0] IDX_MASKED = 3'd5;
  localparam logic [2:0] IDX_BGLOAD = 3'd6;

  typedef enum logic [1:0] {
    PSC_1    = 2'b00,
    PSC_16   = 2'b01,
    PSC_256  = 2'b10,
    PSC_1ALT = 2'b11
  } psc_e;

  typedef struct packed {
    logic       run;       // bit 7
    logic       periodic;  // bit 6
    logic       ie;        // bit 5
    logic       spare;     // bit 4
    logic [1:0] psc;       // bits 3:2
    logic       wide;      // bit 1
    logic       oneshot;   // bit 0
  } ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h20;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import timer_pkg::*;
#(
  parameter int unsigned LO_LOG2 = 4,
  parameter int unsigned HI_LOG2 = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  psc_e sel_i,
  output logic tick_o
);

  logic [HI_LOG2-1:0] div_q;
  logic               hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (clear_i) div_q <= '0;
    else              div_q <= div_q + HI_LOG2'(1);
  end

  always_comb begin
    unique case (sel_i)
      PSC_16:  hit = &div_q[LO_LOG2-1:0];
      PSC_256: hit = &div_q;
      default: hit = 1'b1;
    endcase
  end

  assign tick_o = run_i & hit;

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             ctrl_wr_i,
  input  logic             tick_i,
  input  logic             wide_i,
  input  logic             periodic_i,
  input  logic             oneshot_i,
  output logic [CNT_W-1:0] value_o,
  output logic             expire_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] eff;
  logic             done_q;
  logic             at_zero;

  generate
    if (NARROW_W >= CNT_W) begin : g_full_only
      logic unused_wide;
      assign unused_wide = wide_i;
      assign mask = '1;
    end else begin : g_narrow
      assign mask = wide_i ? '1 : {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    end
  endgenerate

  assign eff      = cnt_q & mask;
  assign at_zero  = (eff == '0);
  assign expire_o = tick_i & at_zero & ~done_q & ~load_wr_i;
  assign value_o  = eff;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (load_wr_i) begin
      cnt_q  <= load_val_i;
      done_q <= 1'b0;
    end else begin
      if (ctrl_wr_i)                  done_q <= 1'b0;
      else if (expire_o && oneshot_i) done_q <= 1'b1;
      if (tick_i && !done_q) begin
        if (!at_zero)        cnt_q <= eff - CNT_W'(1);
        else if (oneshot_i)  cnt_q <= eff;
        else if (periodic_i) cnt_q <= reload_val_i & mask;
        else                 cnt_q <= mask;
      end
    end
  end

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic raw_o,
  output logic irq_o
);

  logic raw_q;

  // expiry beats a clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    raw_q <= 1'b0;
    else if (set_i) raw_q <= 1'b1;
    else if (clr_i) raw_q <= 1'b0;
  end

  assign raw_o = raw_q;
  assign irq_o = raw_q & en_i;

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import timer_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned NARROW_W    = 16,
  parameter int unsigned PSC_LO_LOG2 = 4,
  parameter int unsigned PSC_HI_LOG2 = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);

  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

  logic [IDX_W-1:0] idx;
  logic             in_window;
  logic             wr;
  logic             load_wr, bg_wr, ctrl_wr, iclr_wr;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt_val;
  logic             tick, expire, os_done, raw_q;

  assign idx       = addr_i[IDX_MSB:IDX_LSB];
  assign in_window = (addr_i[ADDR_W-1:IDX_MSB+1] == '0) && (addr_i[IDX_LSB-1:0] == '0);
  assign wr        = req_i & we_i & in_window;
  assign load_wr   = wr && (idx == IDX_LOAD);
  assign bg_wr     = wr && (idx == IDX_BGLOAD);
  assign ctrl_wr   = wr && (idx == IDX_CTRL);
  assign iclr_wr   = wr && (idx == IDX_ICLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= ctrl_t'(CTRL_RESET);
      load_q <= '0;
    end else begin
      if (load_wr || bg_wr) load_q <= wdata_i[CNT_W-1:0];
      if (ctrl_wr)          ctrl_q <= ctrl_t'(wdata_i[7:0]);
    end
  end

  tmr_prescaler #(
    .LO_LOG2 (PSC_LO_LOG2),
    .HI_LOG2 (PSC_HI_LOG2)
  ) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (ctrl_wr),
    .run_i   (ctrl_q.run),
    .sel_i   (psc_e'(ctrl_q.psc)),
    .tick_o  (tick)
  );

  tmr_counter #(
    .CNT_W    (CNT_W),
    .NARROW_W (NARROW_W)
  ) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_wr_i    (load_wr),
    .load_val_i   (wdata_i[CNT_W-1:0]),
    .reload_val_i (load_q),
    .ctrl_wr_i    (ctrl_wr),
    .tick_i       (tick),
    .wide_i       (ctrl_q.wide),
    .periodic_i   (ctrl_q.periodic),
    .oneshot_i    (ctrl_q.oneshot),
    .value_o      (cnt_val),
    .expire_o     (expire),
    .done_o       (os_done)
  );

  tmr_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .clr_i  (iclr_wr),
    .en_i   (ctrl_q.ie),
    .raw_o  (raw_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (in_window) begin
      unique case (idx)
        IDX_LOAD, IDX_BGLOAD: rdata_o[CNT_W-1:0] = load_q;
        IDX_VALUE:            rdata_o[CNT_W-1:0] = cnt_val;
        IDX_CTRL:             rdata_o[7:0]       = ctrl_q;
        IDX_RAW:              rdata_o[0]         = raw_q;
        IDX_MASKED:           rdata_o[0]         = raw_q & ctrl_q.ie;
        default:              rdata_o            = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NARROW_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic              tick,
  input logic              expire,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              raw_q,
  input logic              run,
  input logic              wide,
  input logic              periodic,
  input logic              oneshot,
  input logic              load_wr,
  input logic              ctrl_wr,
  input logic              iclr_wr,
  input logic              os_done
);

  localparam logic [CNT_W-1:0]  NARROW_ONES = {CNT_W{1'b1}} >> (CNT_W - NARROW_W);
  localparam logic [ADDR_W-1:0] MIS_ADDR    = ADDR_W'(20);

  assert_mis_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == MIS_ADDR) |-> (rdata_o[0] == irq_o));

  assert_decrement_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !expire && !load_wr && !ctrl_wr && !os_done) |=> (cnt_val == $past(cnt_val) - CNT_W'(1)));

  assert_hold_stopped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !load_wr && !ctrl_wr) |=> $stable(cnt_val));

  assert_raw_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> raw_q);

  assert_raw_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iclr_wr && !expire) |=> !raw_q);

  assert_free_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !periodic && !oneshot && !ctrl_wr) |=> (cnt_val == (wide ? {CNT_W{1'b1}} : NARROW_ONES)));

  assert_upper_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide |-> ((cnt_val & ~NARROW_ONES) == '0));

  assert_oneshot_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os_done |-> !expire);

  assert_load_now_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr |=> (cnt_val == ($past(wdata_i[CNT_W-1:0]) & (wide ? {CNT_W{1'b1}} : NARROW_ONES))));

endmodule

bind countdown_timer tmr_checker #(
  .ADDR_W   (ADDR_W),
  .CNT_W    (CNT_W),
  .NARROW_W (NARROW_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .tick     (tick),
  .expire   (expire),
  .cnt_val  (cnt_val),
  .raw_q    (raw_q),
  .run      (ctrl_q.run),
  .wide     (ctrl_q.wide),
  .periodic (ctrl_q.periodic),
  .oneshot  (ctrl_q.oneshot),
  .load_wr  (load_wr),
  .ctrl_wr  (ctrl_wr),
  .iclr_wr  (iclr_wr),
  .os_done  (os_done)
);

// File: tb/tb_countdown_timer.sv
module tb_countdown_timer;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int NVEC       = 32;

  localparam logic [1:0] OP_WR   = 2'd0;
  localparam logic [1:0] OP_RD   = 2'd1;
  localparam logic [1:0] OP_IDLE = 2'd2;

  localparam logic [11:0] A_LOAD = 12'h00, A_VAL = 12'h04, A_CTRL = 12'h08, A_ICLR = 12'h0C;
  localparam logic [11:0] A_RIS  = 12'h10, A_MIS = 12'h14, A_BGL  = 12'h18;

  // {op, byte address, data or expected, expected irq}
  localparam logic [42:0] VEC [NVEC] = '{
    {OP_RD,   8'h08, 32'h0000_0020, 1'b0},  // R1
    {OP_RD,   8'h04, 32'h0000_0000, 1'b0},  // R1
    {OP_RD,   8'h10, 32'h0000_0000, 1'b0},  // R1
    {OP_RD,   8'h14, 32'h0000_0000, 1'b0},  // R11
    {OP_WR,   8'h00, 32'h0001_2345, 1'b0},
    {OP_RD,   8'h00, 32'h0001_2345, 1'b0},  // R2
    {OP_RD,   8'h18, 32'h0001_2345, 1'b0},  // R2
    {OP_RD,   8'h04, 32'h0000_2345, 1'b0},  // R12
    {OP_WR,   8'h04, 32'h0000_FFFF, 1'b0},
    {OP_RD,   8'h04, 32'h0000_2345, 1'b0},  // R3
    {OP_RD,   8'h1C, 32'h0000_0000, 1'b0},  // R2
    {OP_RD,   8'h0C, 32'h0000_0000, 1'b0},  // R2
    {OP_WR,   8'h40, 32'hFFFF_FFFF, 1'b0},
    {OP_RD,   8'h08, 32'h0000_0020, 1'b0},  // R2
    {OP_RD,   8'h00, 32'h0001_2345, 1'b0},  // R2
    {OP_WR,   8'h08, 32'h0000_0002, 1'b0},
    {OP_RD,   8'h04, 32'h0001_2345, 1'b0},  // R12
    {OP_RD,   8'h08, 32'h0000_0002, 1'b0},  // R2
    {OP_WR,   8'h00, 32'h0000_0003, 1'b0},
    {OP_WR,   8'h08, 32'h0000_00E2, 1'b0},
    {OP_RD,   8'h04, 32'h0000_0002, 1'b0},  // R5
    {OP_RD,   8'h04, 32'h0000_0001, 1'b0},  // R5
    {OP_RD,   8'h10, 32'h0000_0000, 1'b0},  // R10
    {OP_RD,   8'h10, 32'h0000_0001, 1'b1},  // R10
    {OP_RD,   8'h04, 32'h0000_0002, 1'b1},  // R8
    {OP_RD,   8'h14, 32'h0000_0001, 1'b1},  // R11
    {OP_WR,   8'h08, 32'h0000_0062, 1'b0},
    {OP_WR,   8'h0C, 32'h0000_0000, 1'b0},
    {OP_RD,   8'h10, 32'h0000_0000, 1'b0},  // R10
    {OP_RD,   8'h04, 32'h0000_0000, 1'b0},  // R5
    {OP_IDLE, 8'h00, 32'h0000_0005, 1'b0},
    {OP_RD,   8'h04, 32'h0000_0000, 1'b0}   // R5
  };

  localparam logic [23:0] VTAG [NVEC] = '{
    "R1 ", "R1 ", "R1 ", "R11", "-- ", "R2 ", "R2 ", "R12",
    "-- ", "R3 ", "R2 ", "R2 ", "-- ", "R2 ", "R2 ", "-- ",
    "R12", "R2 ", "-- ", "-- ", "R5 ", "R5 ", "R10", "R10",
    "R8 ", "R11", "-- ", "-- ", "R10", "R5 ", "-- ", "R5 "
  };

  logic              clk   = 1'b0;
  logic              rst_n = 1'b0;
  logic              req   = 1'b0;
  logic              we    = 1'b0;
  logic [ADDR_W-1:0] addr  = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              irq;
  int                checks = 0;
  int                errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  countdown_timer dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // drives at the current falling edge; the write lands on the next rising edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input logic ei, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, "rdata", rdata, e);
    check(tag, "irq", {31'b0, irq}, {31'b0, ei});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][42:41])
        OP_WR:   wr({4'h0, VEC[i][40:33]}, VEC[i][32:1]);
        OP_RD:   rd({4'h0, VEC[i][40:33]}, VEC[i][32:1], VEC[i][0], $sformatf("%s vec%0d", VTAG[i], i));
        default: idle(int'(VEC[i][32:1]));
      endcase
    end

    // R7: 16-bit free-running wrap
    wr(A_LOAD, 32'd1);
    wr(A_CTRL, 32'h80);
    rd(A_VAL, 32'h0, 1'b0, "R5");
    rd(A_VAL, 32'h0000_FFFF, 1'b0, "R7");
    rd(A_RIS, 32'h1, 1'b0, "R10");
    rd(A_MIS, 32'h0, 1'b0, "R11");

    // R7: 32-bit free-running wrap
    wr(A_CTRL, 32'h00);
    wr(A_ICLR, 32'h0);
    wr(A_LOAD, 32'd1);
    wr(A_CTRL, 32'h82);
    rd(A_VAL, 32'h0, 1'b0, "R7");
    rd(A_VAL, 32'hFFFF_FFFF, 1'b0, "R7");

    // R4: deferred start value is used at the next refill only
    wr(A_CTRL, 32'h00);
    wr(A_ICLR, 32'h0);
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, 32'hC0);
    wr(A_BGL, 32'd9);
    rd(A_VAL, 32'd0, 1'b0, "R4");
    rd(A_VAL, 32'd9, 1'b0, "R4");
    rd(A_LOAD, 32'd9, 1'b0, "R4");

    // R9: one-shot fires once and parks at zero
    wr(A_CTRL, 32'h00);
    wr(A_ICLR, 32'h0);
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, 32'hA1);
    idle(4);
    rd(A_VAL, 32'd0, 1'b1, "R9");
    rd(A_RIS, 32'd1, 1'b1, "R9");
    wr(A_ICLR, 32'h0);
    idle(3);
    rd(A_RIS, 32'd0, 1'b0, "R9");
    rd(A_VAL, 32'd0, 1'b0, "R9");

    // R6: divide by 16, phase restarted by the control write
    wr(A_CTRL, 32'h00);
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, 32'h84);
    idle(14);
    rd(A_VAL, 32'd3, 1'b0, "R6");
    rd(A_VAL, 32'd2, 1'b0, "R6");

    // R6: divide by 256
    wr(A_CTRL, 32'h88);
    idle(254);
    rd(A_VAL, 32'd2, 1'b0, "R6");
    rd(A_VAL, 32'd1, 1'b0, "R6");

    // R10: expiry and clear on the same edge, expiry wins
    wr(A_CTRL, 32'h00);
    wr(A_ICLR, 32'h0);
    wr(A_LOAD, 32'd1);
    wr(A_CTRL, 32'hA1);
    idle(1);
    wr(A_ICLR, 32'h0);
    rd(A_RIS, 32'd1, 1'b1, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule